// File: doc/BRIEF.md
# Overlapping 1101 Serial Pattern Detector

This block watches a one-bit serial stream and flags every occurrence of the bit pattern 1101. The input is sampled on each rising clock edge. Matches may overlap: the final 1 of one match can serve as the first 1 of the next, so the stream 1101101 yields two detections.

An elaboration parameter `MEALY` picks the output style. With `MEALY = 1` the machine has four states in two bits, coded idle = 00, saw "1" = 01, saw "11" = 11, saw "110" = 10. The flag `z` is formed from the present state and the live input, so it rises during the cycle in which the closing 1 is present, before the edge that samples it. With `MEALY = 0` a fifth state, coded 100, is added in a three-bit register; `z` is decoded from the state alone and is high for the whole clock cycle after the edge that sampled the closing 1. In that style any of the three unused codes returns to idle on the next edge. An asynchronous active-high reset puts either variant in idle (all zeros) at once.

Top module: `seq_1101_det`

## Requirements
- R1: While `rst` is high, `z` is 0 and the state is idle. A partial match held before reset is forgotten, so "110", then reset, then "1" gives no detection.
- R2: With `MEALY = 1`, `z` is 1 exactly when `x` is 1 and the three samples taken most recently since reset were 1, 1, 0 in that order.
- R3: With `MEALY = 1`, `z` follows changes on `x` between clock edges without waiting for an edge.
- R4: Detections overlap: after a detection the machine keeps the closing 1 as a prefix, so 1101101 flags on the 4th and 7th bits. Two detections are never on consecutive cycles.
- R5: With `MEALY = 0`, `z` is 1 for the cycle after the edge that sampled the closing 1 of 1101, and 0 otherwise.
- R6: With `MEALY = 0`, `z` does not change when `x` changes between edges.
- R7: A run of three or more 1s followed by 0 then 1 is detected once, at the closing 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. The state moves on its rising edge |
| rst | input | 1 | Asynchronous reset, active high, forces idle |
| x | input | 1 | Serial data bit |
| z | output | 1 | High when the pattern 1101 has completed |

## Verification
The bench builds two copies side by side, one with `MEALY = 1` and one with `MEALY = 0`, and drives both with the same stream. This covers both generate branches, including the fifth state and its exits. Both outputs are compared with a four-sample history model: the live-input style uses the last three samples plus the current bit, and the state-only style uses the last four samples. Seeded random streams weighted toward 1s produce many overlapping and near-miss patterns. Directed sequences cover the double overlap, long runs of 1s, input toggling between edges, and a reset in the middle of a partial match.

// File: rtl/seq_1101_det.sv
module seq_1101_det #(
  parameter bit MEALY = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic x,
  output logic z
);
  localparam int SW = MEALY ? 2 : 3;
  localparam logic [SW-1:0] IDLE  = SW'(0);
  localparam logic [SW-1:0] ONE   = SW'(1);
  localparam logic [SW-1:0] ONE1  = SW'(3);
  localparam logic [SW-1:0] ONE10 = SW'(2);

  logic [SW-1:0] state, nxt;

  always_ff @(posedge clk or posedge rst)
    if (rst) state <= IDLE;
    else     state <= nxt;

  generate
    if (MEALY) begin : g_mealy
      always_comb
        case (state)
          IDLE:    nxt = x ? ONE  : IDLE;
          ONE:     nxt = x ? ONE1 : IDLE;
          ONE1:    nxt = x ? ONE1 : ONE10;
          default: nxt = x ? ONE  : IDLE;
        endcase
      assign z = (state == ONE10) & x;
    end else begin : g_moore
      localparam logic [SW-1:0] HIT = SW'(4);
      always_comb
        case (state)
          IDLE:    nxt = x ? ONE  : IDLE;
          ONE:     nxt = x ? ONE1 : IDLE;
          ONE1:    nxt = x ? ONE1 : ONE10;
          ONE10:   nxt = x ? HIT  : IDLE;
          HIT:     nxt = x ? ONE1 : IDLE;
          default: nxt = IDLE;
        endcase
      assign z = (state == HIT);
    end
  endgenerate
endmodule

// File: rtl/seq_1101_det_chk.sv
module seq_1101_det_chk #(
  parameter bit MEALY = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic x,
  input logic z,
  input logic [(MEALY ? 2 : 3)-1:0] st
);
  AST_RST_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (st == '0)); // R1

  AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
    z |=> !z); // R4

  generate
    if (MEALY) begin : g_m
      AST_MEALY_PREFIX: assert property (@(posedge clk) disable iff (rst)
        z |-> (x && !$past(x) && $past(x, 2) && $past(x, 3))); // R2
      AST_MEALY_RESTART: assert property (@(posedge clk) disable iff (rst)
        z |=> (st == 2'b01)); // R4
    end else begin : g_o
      AST_MOORE_PREFIX: assert property (@(posedge clk) disable iff (rst)
        z |-> ($past(x) && !$past(x, 2) && $past(x, 3) && $past(x, 4))); // R5
      AST_MOORE_RESTART: assert property (@(posedge clk) disable iff (rst)
        z |=> (st == 3'b011 || st == 3'b000)); // R4
    end
  endgenerate
endmodule

bind seq_1101_det seq_1101_det_chk #(.MEALY(MEALY)) u_chk (
  .clk(clk), .rst(rst), .x(x), .z(z), .st(state)
);

// File: tb/seq_1101_det_tb.sv
module seq_1101_det_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic x = 1'b0;
  logic z_mealy, z_moore;
  logic [3:0] hist = 4'b0000;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  seq_1101_det #(.MEALY(1'b1)) u_dut (
    .clk(clk), .rst(rst), .x(x), .z(z_mealy)
  );
  seq_1101_det #(.MEALY(1'b0)) u_dut_moore (
    .clk(clk), .rst(rst), .x(x), .z(z_moore)
  );

  function automatic logic exp_mealy(logic [3:0] h, logic b);
    return {h[2:0], b} == 4'b1101;
  endfunction

  function automatic logic exp_moore(logic [3:0] h);
    return h == 4'b1101;
  endfunction

  task automatic check(logic act, logic exp, string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
    end
  endtask

  task automatic step(logic b, string rm, string ro);
    check(z_moore, exp_moore(hist), ro);
    x = b;
    #1;
    check(z_mealy, exp_mealy(hist, b), rm);
    hist = {hist[2:0], b};
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    x = 1'b1;
    #1;
    check(z_mealy, 1'b0, "R1");
    check(z_moore, 1'b0, "R1");
    hist = 4'b0000;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [6:0] ov;
    void'($urandom(32'd1101));
    @(negedge clk);
    check(z_mealy, 1'b0, "R1");
    check(z_moore, 1'b0, "R1");
    @(negedge clk);
    rst = 1'b0;

    ov = 7'b1101101;
    for (int i = 6; i >= 0; i--) step(ov[i], "R4", "R4");
    check(z_moore, 1'b1, "R4");
    step(1'b0, "R4", "R5");

    for (int i = 0; i < 5; i++) step(1'b1, "R7", "R7");
    step(1'b0, "R7", "R7");
    step(1'b1, "R7", "R7");
    check(z_moore, 1'b1, "R7");
    step(1'b0, "R7", "R5");

    step(1'b1, "R2", "R5");
    step(1'b1, "R2", "R5");
    step(1'b0, "R2", "R5");
    x = 1'b0; #1; check(z_mealy, 1'b0, "R3");
    x = 1'b1; #1; check(z_mealy, 1'b1, "R3");
    x = 1'b0; #1; check(z_mealy, 1'b0, "R3");
    check(z_moore, 1'b0, "R6");
    x = 1'b1; #1; check(z_mealy, 1'b1, "R3");
    check(z_moore, 1'b0, "R6");
    hist = {hist[2:0], 1'b1};
    @(negedge clk);
    x = 1'b0; #1; check(z_moore, 1'b1, "R6");
    x = 1'b1; #1; check(z_moore, 1'b1, "R6");
    step(1'b0, "R2", "R5");

    step(1'b1, "R1", "R1");
    step(1'b1, "R1", "R1");
    step(1'b0, "R1", "R1");
    do_reset();
    step(1'b1, "R1", "R1");
    step(1'b0, "R1", "R1");

    for (int i = 0; i < 600; i++) begin
      if (i % 97 == 50) do_reset();
      step(($urandom % 4) != 0, "R2", "R5");
    end
    finish_run();
  end
endmodule